// File: doc/BRIEF.md
# Stereo Serial Audio Framer

This block turns pairs of 20-bit signed PCM samples into the three-wire serial stream an external stereo DAC expects: a bit clock, a left/right word-select line and one serial data line. It runs from a master clock at 256 times the sample rate. The bit clock is the master clock divided by four. That gives 64 bit clocks per frame and 32 bit slots per channel.

A single format pin picks the framing. In I2S mode word select is low for the left channel. The MSB follows one bit clock after each word-select change, and the word length is 16, 18 or 20 bits. In right-justified mode word select is high for the left channel. The top 16 bits of the sample end exactly in the last slot of each half. All other slots carry 0. Word select and data are updated on the falling bit-clock edge, so they are steady when the DAC samples on the rising edge.

Once per frame the block pulses a request. The pair present on the sample inputs at the clock edge that raises the request is captured and sent in the frame that starts on that same edge. The format and word-length inputs are also taken at that edge.

A small state machine tracks the region of the current slot inside a half frame:
- OFF: reset or sleep.
- LEAD: leading zero slots.
- BITS: sample bits.
- TAIL: trailing zero slots, which exist only in I2S mode.

Its transitions are:
- wake: OFF to LEAD.
- first bit: LEAD to BITS.
- word done: BITS to TAIL.
- half wrap: BITS or TAIL to LEAD.
- sleep: any state to OFF.

Top module: `audio_serializer`

## Requirements
- R1: `bclk` is the master clock divided by 4: high for 2 and low for 2 master cycles. There are 64 bit clocks per frame and 32 per half frame.
- R2: `lrck` and `sdata` change only on a master edge where `bclk` falls. They hold steady for the full bit slot.
- R3: With `fmt_sel` = 0 (I2S), `lrck` is 0 for the 32 slots of the left half and 1 for the 32 slots of the right half.
- R4: In I2S mode, slot p (0..31) of each half carries sample bit 20-p for 1 <= p <= N, which sends the MSB first. All other slots carry 0. N is 16, 18 or 20 for `word_len` = 00, 01 or 1x, so shorter words keep the top bits.
- R5: With `fmt_sel` = 1 (right-justified), `lrck` is 1 for the left half and 0 for the right half. Slots 16..31 carry sample bits 19 down to 4, with the LSB in slot 31. Slots 0..15 carry 0, and `word_len` is ignored.
- R6: `smp_req` is a one-cycle pulse that recurs every 256 master cycles. The pair on `left_in`/`right_in` at the edge that raises it is sent in the frame starting at that edge, left half first.
- R7: `fmt_sel`, `word_len` and the sample inputs are sampled only at the capture edge. Changing them mid-frame leaves the frame in progress unchanged.
- R8: While `rst_n` is low, `bclk`, `lrck`, `sdata` and `smp_req` are 0.
- R9: One cycle after `sleep` is seen high, all four outputs are 0 and stay 0 while it is high. The first edge with `sleep` low captures a new pair and starts a new frame with the left half.
- R10: The first edge after reset release is a capture edge, so the first frame carries the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 x sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Synchronous power-down, active high; forces outputs to 0 |
| fmt_sel | input | 1 | 0 = I2S, 1 = right-justified 16-bit |
| word_len | input | 2 | I2S word length: 00 = 16, 01 = 18, 1x = 20 bits |
| left_in | input | 20 | Left sample, signed |
| right_in | input | 20 | Right sample, signed |
| smp_req | output | 1 | One-cycle pulse at each capture edge |
| bclk | output | 1 | Serial bit clock |
| lrck | output | 1 | Left/right word select |
| sdata | output | 1 | Serial stereo data, MSB first |

## Verification
Several things land on the same master edge at every frame boundary:
- capture of a new pair;
- latching of a possibly different format;
- the left-word reload of the shift register;
- the next word-select level.

The bench provokes this by switching format, word length and samples in the middle of each frame. It then decodes the next whole frame from the pins, slot by slot. The decoded frame must show the new setting intact while the frame in progress keeps the old one. A second coincidence, leaving sleep on the very edge that captures, is judged the same way: the first frame after wake must be a clean left-first frame carrying the pair present at release.

// File: rtl/aser_pkg.sv
`timescale 1ns/1ps
package aser_pkg;

    localparam int SAMPLE_W = 20;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_LEAD,
        ST_BITS,
        ST_TAIL
    } slot_st_e;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_RJ  = 1'b1
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wl;
    } cfg_t;

    // number of sample bits sent per half in I2S mode
    function automatic logic [4:0] wl_bits(input logic [1:0] wl);
        logic [4:0] n;
        unique case (wl)
            2'b00:   n = 5'd16;
            2'b01:   n = 5'd18;
            default: n = 5'd20;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/aser_timebase.sv
`timescale 1ns/1ps
module aser_timebase #(
    parameter int DIV_LOG2  = 2,
    parameter int HALF_LOG2 = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    output logic                 bclk_q,
    output logic                 slot_edge,
    output logic                 frame_edge,
    output logic                 nxt_half,
    output logic [HALF_LOG2-1:0] nxt_pos
);

    localparam int CNT_W = 1 + HALF_LOG2 + DIV_LOG2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    // counter parks at all ones so the first running edge opens a frame
    always_comb begin
        cnt_n = run ? cnt_q + CNT_W'(1) : '1;
    end

    assign slot_edge  = run && (&cnt_q[DIV_LOG2-1:0]);
    assign frame_edge = run && (&cnt_q);
    assign nxt_half   = cnt_n[CNT_W-1];
    assign nxt_pos    = cnt_n[CNT_W-2:DIV_LOG2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            bclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            bclk_q <= run & cnt_n[DIV_LOG2-1];
        end
    end

    // R1
    bclk_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_q && $past(bclk_q)) |=> !bclk_q);

    // R1
    bclk_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bclk_q) && run) |=> !bclk_q);

endmodule

// File: rtl/aser_slot_fsm.sv
`timescale 1ns/1ps
module aser_slot_fsm
    import aser_pkg::*;
#(
    parameter int HALF_LOG2 = 5,
    parameter int RJ_W      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 slot_edge,
    input  logic                 nxt_half,
    input  logic [HALF_LOG2-1:0] nxt_pos,
    input  cfg_t                 cfg_n,
    output slot_st_e             st_q,
    output logic                 lrck_q,
    output logic                 shift_go,
    output logic                 load_go
);

    localparam int HALF_N = 1 << HALF_LOG2;

    slot_st_e             st_d;
    logic [HALF_LOG2-1:0] first_pos;
    logic [HALF_LOG2-1:0] end_pos;

    always_comb begin
        first_pos = (cfg_n.fmt == FMT_RJ) ? HALF_LOG2'(HALF_N - RJ_W) : HALF_LOG2'(1);
        end_pos   = HALF_LOG2'(wl_bits(cfg_n.wl)) + HALF_LOG2'(1);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = ST_OFF;
        end else if (slot_edge) begin
            unique case (st_q)
                ST_OFF:  st_d = ST_LEAD;
                ST_LEAD: if (nxt_pos == first_pos) st_d = ST_BITS;
                ST_BITS: begin
                    if (nxt_pos == '0)
                        st_d = ST_LEAD;
                    else if (cfg_n.fmt == FMT_I2S && nxt_pos == end_pos)
                        st_d = ST_TAIL;
                end
                ST_TAIL: if (nxt_pos == '0) st_d = ST_LEAD;
                default: st_d = ST_OFF;
            endcase
        end
    end

    assign shift_go = run && slot_edge && (st_d == ST_BITS);
    assign load_go  = run && slot_edge && (nxt_pos == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lrck_q <= 1'b0;
        else if (!run)       lrck_q <= 1'b0;
        else if (slot_edge)  lrck_q <= nxt_half ^ (cfg_n.fmt == FMT_RJ);
    end

endmodule

// File: rtl/aser_shifter.sv
`timescale 1ns/1ps
module aser_shifter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         slot_edge,
    input  logic         load_go,
    input  logic         shift_go,
    input  logic [W-1:0] load_word,
    output logic         sd_q
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            sd_q <= 1'b0;
        end else if (!run) begin
            sh_q <= '0;
            sd_q <= 1'b0;
        end else begin
            if (load_go)
                sh_q <= load_word;
            else if (shift_go)
                sh_q <= {sh_q[W-2:0], 1'b0};
            if (slot_edge)
                sd_q <= shift_go ? sh_q[W-1] : 1'b0;
        end
    end

endmodule

// File: rtl/audio_serializer.sv
`timescale 1ns/1ps
module audio_serializer
    import aser_pkg::*;
#(
    parameter int DIV_LOG2  = 2,
    parameter int HALF_LOG2 = 5,
    parameter int RJ_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep,
    input  logic                fmt_sel,
    input  logic [1:0]          word_len,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic                smp_req,
    output logic                bclk,
    output logic                lrck,
    output logic                sdata
);

    logic                 run;
    logic                 slot_edge;
    logic                 frame_edge;
    logic                 nxt_half;
    logic [HALF_LOG2-1:0] nxt_pos;
    logic                 shift_go;
    logic                 load_go;
    slot_st_e             st;
    cfg_t                 cfg_q;
    cfg_t                 cfg_n;
    logic [SAMPLE_W-1:0]  hold_r;
    logic [SAMPLE_W-1:0]  load_word;
    logic                 req_q;

    assign run = ~sleep;

    always_comb begin
        if (frame_edge) begin
            cfg_n.fmt = fmt_e'(fmt_sel);
            cfg_n.wl  = word_len;
        end else begin
            cfg_n = cfg_q;
        end
    end

    // left word goes straight in at the frame edge; right waits in hold_r
    assign load_word = nxt_half ? hold_r : left_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '{fmt: FMT_I2S, wl: 2'b00};
            hold_r <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q <= frame_edge;
            if (frame_edge) begin
                cfg_q  <= cfg_n;
                hold_r <= right_in;
            end
        end
    end

    aser_timebase #(
        .DIV_LOG2  (DIV_LOG2),
        .HALF_LOG2 (HALF_LOG2)
    ) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .bclk_q     (bclk),
        .slot_edge  (slot_edge),
        .frame_edge (frame_edge),
        .nxt_half   (nxt_half),
        .nxt_pos    (nxt_pos)
    );

    aser_slot_fsm #(
        .HALF_LOG2 (HALF_LOG2),
        .RJ_W      (RJ_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .slot_edge (slot_edge),
        .nxt_half  (nxt_half),
        .nxt_pos   (nxt_pos),
        .cfg_n     (cfg_n),
        .st_q      (st),
        .lrck_q    (lrck),
        .shift_go  (shift_go),
        .load_go   (load_go)
    );

    aser_shifter #(
        .W (SAMPLE_W)
    ) u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .slot_edge (slot_edge),
        .load_go   (load_go),
        .shift_go  (shift_go),
        .load_word (load_word),
        .sd_q      (sdata)
    );

    assign smp_req = req_q;

    // R2
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lrck) && st != ST_OFF && $past(st) != ST_OFF) |-> $fell(bclk));

    // R2
    sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdata) && st != ST_OFF && $past(st) != ST_OFF) |-> $fell(bclk));

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!bclk && !lrck && !sdata && !smp_req));

    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |=> !smp_req);

    // R5
    rj_no_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TAIL) |-> (cfg_q.fmt == FMT_I2S));

    // R4
    sd_in_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdata |-> (st == ST_BITS));

endmodule

// File: tb/sim_audio_serializer.sv
`timescale 1ns/1ps
module sim_audio_serializer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sleep;
    logic        fmt_sel;
    logic [1:0]  word_len;
    logic [19:0] left_in;
    logic [19:0] right_in;
    logic        smp_req;
    logic        bclk;
    logic        lrck;
    logic        sdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    audio_serializer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .fmt_sel  (fmt_sel),
        .word_len (word_len),
        .left_in  (left_in),
        .right_in (right_in),
        .smp_req  (smp_req),
        .bclk     (bclk),
        .lrck     (lrck),
        .sdata    (sdata)
    );

    // {fmt, word_len, left, right}
    localparam int NV = 6;
    localparam logic [42:0] VECS [0:NV-1] = '{
        {1'b0, 2'b00, 20'hA53C9, 20'h5AC36},
        {1'b0, 2'b01, 20'h80001, 20'h7FFFE},
        {1'b0, 2'b10, 20'hFFFFF, 20'h00001},
        {1'b1, 2'b10, 20'h12345, 20'hFEDCB},
        {1'b1, 2'b00, 20'h8000F, 20'h7FFF0},
        {1'b0, 2'b11, 20'hC0FFE, 20'h0BEEF}
    };
    localparam logic [42:0] WAKE_V = {1'b1, 2'b01, 20'h13579, 20'h2468A};

    task automatic apply(input logic [42:0] v);
        fmt_sel  = v[42];
        word_len = v[41:40];
        left_in  = v[39:20];
        right_in = v[19:0];
    endtask

    function automatic logic [63:0] exp_sd(input logic [42:0] v);
        logic [63:0] r;
        logic [19:0] w;
        int nb;
        nb = (v[41:40] == 2'b00) ? 16 : (v[41:40] == 2'b01) ? 18 : 20;
        for (int s = 0; s < 64; s++) begin
            int p;
            p = s % 32;
            w = (s >= 32) ? v[19:0] : v[39:20];
            if (!v[42]) r[s] = (p >= 1 && p <= nb) ? w[20-p] : 1'b0;
            else        r[s] = (p >= 16) ? w[35-p] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_ws(input logic f);
        logic [63:0] r;
        for (int s = 0; s < 64; s++) r[s] = f ? (s < 32) : (s >= 32);
        return r;
    endfunction

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // called at the negedge where smp_req is seen high (slot 0, phase 0)
    task automatic frame_check(input logic [42:0] v, input bit swap, input logic [42:0] nv);
        logic [63:0] ws;
        logic [63:0] sd;
        logic w0, d0;
        int bclk_err, stab_err, reqs;
        bclk_err = 0; stab_err = 0; reqs = 0; w0 = 1'b0; d0 = 1'b0;
        ws = '0; sd = '0;
        for (int k = 0; k < 256; k++) begin
            if (k > 0) @(negedge clk);
            if (bclk !== ((k >> 1) & 1)) bclk_err++;
            if (smp_req) reqs++;
            if (k % 4 == 0) begin
                w0 = lrck;
                d0 = sdata;
            end else if (lrck !== w0 || sdata !== d0) begin
                stab_err++;
            end
            if (k % 4 == 2) begin
                ws[k/4] = lrck;
                sd[k/4] = sdata;
            end
            if (swap && k == 100) apply(nv);
        end
        chk(ws === exp_ws(v[42]),
            v[42] ? "R5 right-justified word select" : "R3 I2S word select",
            ws, exp_ws(v[42]));
        chk(sd === exp_sd(v),
            v[42] ? "R5 right-justified data, R7 config held" : "R4 I2S data, R7 config held",
            sd, exp_sd(v));
        chk(bclk_err == 0, "R1 bit clock divide by 4", 64'(bclk_err), 64'd0);
        chk(stab_err == 0, "R2 change only at falling bclk", 64'(stab_err), 64'd0);
        chk(reqs == 1, "R6 one request per frame", 64'(reqs), 64'd1);
        @(negedge clk);
        chk(smp_req === 1'b1, "R6 request every 256 cycles", 64'(smp_req), 64'd1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        rst_n = 1'b0;
        sleep = 1'b0;
        apply(VECS[0]);
        repeat (3) @(negedge clk);
        // R8 reset state
        chk({bclk, lrck, sdata, smp_req} === 4'b0, "R8 outputs zero in reset",
            64'({bclk, lrck, sdata, smp_req}), 64'd0);
        repeat (4) @(negedge clk);
        chk({bclk, lrck, sdata, smp_req} === 4'b0, "R8 outputs still zero in reset",
            64'({bclk, lrck, sdata, smp_req}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(smp_req === 1'b1, "R10 capture at first edge after reset", 64'(smp_req), 64'd1);

        // table walk; frame 0 carries the reset-time pair (R10)
        for (int i = 0; i < NV; i++) begin
            frame_check(VECS[i], i < NV - 1, (i < NV - 1) ? VECS[i+1] : VECS[i]);
        end

        // sleep in the middle of a frame
        repeat (130) @(negedge clk);
        sleep = 1'b1;
        @(negedge clk);
        chk({bclk, lrck, sdata, smp_req} === 4'b0, "R9 outputs zero after sleep",
            64'({bclk, lrck, sdata, smp_req}), 64'd0);
        begin
            int bad;
            bad = 0;
            repeat (40) begin
                @(negedge clk);
                if ({bclk, lrck, sdata, smp_req} !== 4'b0) bad++;
            end
            chk(bad == 0, "R9 quiet while asleep", 64'(bad), 64'd0);
        end
        apply(WAKE_V);
        sleep = 1'b0;
        @(negedge clk);
        chk(smp_req === 1'b1, "R9 capture on wake edge", 64'(smp_req), 64'd1);
        frame_check(WAKE_V, 1'b0, WAKE_V);

        // reset in the middle of operation
        repeat (77) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({bclk, lrck, sdata, smp_req} === 4'b0, "R8 outputs zero on mid-run reset",
            64'({bclk, lrck, sdata, smp_req}), 64'd0);
        apply(VECS[2]);
        rst_n = 1'b1;
        @(negedge clk);
        chk(smp_req === 1'b1, "R10 capture after second reset", 64'(smp_req), 64'd1);
        frame_check(VECS[2], 1'b0, VECS[2]);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule